// File: doc/BRIEF.md
# Dual-Clock FIFO Status Flag Generator

This block derives the five status flags of a dual-clock FIFO from its write and read pointers: empty, almost-empty, half-full, almost-full and full, all active low. The write pointer lives in the write clock domain and the read pointer in the read clock domain. Each pointer is converted to Gray code, passed through a two-stage synchronizer into the other domain, and converted back to binary. The word count in each domain is the difference of the two pointers, taken modulo the pointer width. The almost-empty threshold comes from an empty offset input and the almost-full threshold from a full offset input.

Two options are captured in the cycles right after reset release. The buffering option selects standard operation or first-word-fall-through operation. In first-word-fall-through operation the output register holds one more word, so every threshold moves up by one. The timing option selects synchronous or asynchronous partial flags. In synchronous timing, almost-empty is computed and registered only in the read domain, and almost-full only in the write domain. In asynchronous timing, a partial flag is asserted by the clock of the side that drains or fills the FIFO, and released by the clock of the opposite side. Empty is always driven from the read domain. Full and half-full are always driven from the write domain.

Top module: `fifo_flag_gen`

## Requirements
- R1: While reset is asserted and until the local reset releases, empty and almost-empty are low and half-full, almost-full and full are high.
- R2: Empty is low exactly when the read-domain count is 0.
- R3: In standard operation with empty offset n, almost-empty is low for counts 0..n and high for counts above n.
- R4: In standard operation with depth D and full offset m, almost-full is low for counts of D-m and above, and full is low at a count of D.
- R5: Half-full is low when the count exceeds D/2 in standard operation.
- R6: In first-word-fall-through operation every threshold rises by one: almost-empty is low up to n+1, half-full goes low above D/2+1, almost-full goes low at D-m+1, and full goes low at D+1.
- R7: In asynchronous timing, almost-empty goes high on the first write-clock edge that sees the count above its threshold, and goes low on the first read-clock edge that sees the count at or below it. Almost-full goes low on the first write-clock edge that sees the count at or above its threshold.
- R8: In synchronous timing, almost-empty changes only through the read clock. A write-clock edge that raises the count does not raise the flag until the pointer has crossed into the read domain.
- R9: The two option pins (buffering: 1 = first-word-fall-through; timing: 1 = asynchronous) are captured only while the local reset is held. Changing them afterwards has no effect on the flags.
- R10: Counts are pointer differences modulo 2^PW (PW = log2(D)+2), so the flags are correct across pointer wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fwft_i | input | 1 | Buffering option, captured at reset (1 = first-word-fall-through) |
| cfg_async_i | input | 1 | Partial-flag timing option, captured at reset (1 = asynchronous) |
| wptr_i | input | PW | Binary write pointer, write domain |
| rptr_i | input | PW | Binary read pointer, read domain |
| empty_off_i | input | OW | Almost-empty offset n |
| full_off_i | input | OW | Almost-full offset m |
| empty_n_o | output | 1 | Empty, active low |
| almost_empty_n_o | output | 1 | Almost-empty, active low |
| half_full_n_o | output | 1 | Half-full, active low |
| almost_full_n_o | output | 1 | Almost-full, active low |
| full_n_o | output | 1 | Full, active low |

## Verification
The hardest situation to reach is the exact edge at which an asynchronous partial flag changes. That edge belongs to one clock, and the other domain has not yet seen the new pointer. The bench offsets the two clocks by 3 ns and moves a single pointer by one word between edges. It then samples 1 ns after the first edge of the owning clock, before the other clock can respond. The same stimulus is repeated in synchronous timing, where the flag must still hold its old value at that point. The threshold rows are placed one word on either side of each boundary, in both buffering modes, and include rows whose pointers wrap.

// File: rtl/ffg_pkg.sv
package ffg_pkg;
  typedef enum logic {
    TM_SYNC  = 1'b0,
    TM_ASYNC = 1'b1
  } ffg_timing_e;

  typedef struct packed {
    logic        fwft;
    ffg_timing_e timing;
  } ffg_mode_t;
endpackage

// File: rtl/ffg_sync.sv
module ffg_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ffg_rst_sync.sv
module ffg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_o
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_s_o = sh_q[1];
endmodule

// File: rtl/ffg_ptr_xfer.sv
module ffg_ptr_xfer #(
  parameter int W = 8
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] bin_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] gray_q, gray_s;

  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) gray_q <= '0;
    else        gray_q <= bin_i ^ (bin_i >> 1);
  end

  ffg_sync #(.W(W)) sync_i (
    .clk(dst_clk), .rst_n(rst_n), .d_i(gray_q), .q_o(gray_s)
  );

  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(gray_s >> i);
  end
endmodule

// File: rtl/fifo_flag_gen.sv
module fifo_flag_gen
  import ffg_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OW    = $clog2(DEPTH),
  parameter int PW    = $clog2(DEPTH) + 2
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          cfg_fwft_i,
  input  logic          cfg_async_i,
  input  logic [PW-1:0] wptr_i,
  input  logic [PW-1:0] rptr_i,
  input  logic [OW-1:0] empty_off_i,
  input  logic [OW-1:0] full_off_i,
  output logic          empty_n_o,
  output logic          almost_empty_n_o,
  output logic          half_full_n_o,
  output logic          almost_full_n_o,
  output logic          full_n_o
);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_CNT = PW'(DEPTH / 2);

  // local resets and option capture
  logic rst_ws, rst_rs;
  ffg_mode_t w_mode_q, w_mode_d, r_mode_q, r_mode_d;

  ffg_rst_sync wrst_i (.clk(wclk), .rst_n(rst_n), .rst_s_o(rst_ws));
  ffg_rst_sync rrst_i (.clk(rclk), .rst_n(rst_n), .rst_s_o(rst_rs));

  always_comb begin
    w_mode_d = w_mode_q;
    r_mode_d = r_mode_q;
    if (!rst_ws) w_mode_d = '{fwft: cfg_fwft_i, timing: ffg_timing_e'(cfg_async_i)};
    if (!rst_rs) r_mode_d = '{fwft: cfg_fwft_i, timing: ffg_timing_e'(cfg_async_i)};
  end

  // pointer crossing
  logic [PW-1:0] rptr_ws, wptr_rs, wcnt, rcnt;

  ffg_ptr_xfer #(.W(PW)) w2r_i (
    .src_clk(wclk), .dst_clk(rclk), .rst_n(rst_n), .bin_i(wptr_i), .bin_o(wptr_rs)
  );
  ffg_ptr_xfer #(.W(PW)) r2w_i (
    .src_clk(rclk), .dst_clk(wclk), .rst_n(rst_n), .bin_i(rptr_i), .bin_o(rptr_ws)
  );

  assign wcnt = wptr_i - rptr_ws;
  assign rcnt = wptr_rs - rptr_i;

  // thresholds per domain
  logic [PW-1:0] w_pae_thr, w_paf_thr, w_full_thr, w_hf_thr, r_pae_thr, r_paf_thr;
  assign w_pae_thr  = PW'(empty_off_i) + PW'(w_mode_q.fwft);
  assign w_paf_thr  = FULL_CNT - PW'(full_off_i) + PW'(w_mode_q.fwft);
  assign w_full_thr = FULL_CNT + PW'(w_mode_q.fwft);
  assign w_hf_thr   = HALF_CNT + PW'(w_mode_q.fwft);
  assign r_pae_thr  = PW'(empty_off_i) + PW'(r_mode_q.fwft);
  assign r_paf_thr  = FULL_CNT - PW'(full_off_i) + PW'(r_mode_q.fwft);

  // toggle pairs for asynchronous partial flags:
  // almost-empty high = hi_w ^ lo_r ; almost-full low = lo_w ^ hi_r
  logic hi_w_q, hi_w_d, lo_w_q, lo_w_d, lo_r_q, lo_r_d, hi_r_q, hi_r_d;
  logic [1:0] r_tog_ws, w_tog_rs;

  ffg_sync #(.W(2)) tr2w_i (.clk(wclk), .rst_n(rst_n), .d_i({lo_r_q, hi_r_q}), .q_o(r_tog_ws));
  ffg_sync #(.W(2)) tw2r_i (.clk(rclk), .rst_n(rst_n), .d_i({hi_w_q, lo_w_q}), .q_o(w_tog_rs));

  // write domain
  logic full_n_q, full_n_d, hf_n_q, hf_n_d, paf_n_q, paf_n_d;
  logic w_async;
  assign w_async = (w_mode_q.timing == TM_ASYNC);

  always_comb begin
    full_n_d = !(wcnt >= w_full_thr);
    hf_n_d   = !(wcnt >  w_hf_thr);
    paf_n_d  = !(wcnt >= w_paf_thr);
    hi_w_d   = hi_w_q;
    lo_w_d   = lo_w_q;
    if (w_async && (wcnt > w_pae_thr) && !(hi_w_q ^ r_tog_ws[1])) hi_w_d = ~hi_w_q;
    if (w_async && (wcnt >= w_paf_thr) && !(lo_w_q ^ r_tog_ws[0])) lo_w_d = ~lo_w_q;
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      w_mode_q <= '{fwft: 1'b0, timing: TM_SYNC};
      full_n_q <= 1'b1;
      hf_n_q   <= 1'b1;
      paf_n_q  <= 1'b1;
      hi_w_q   <= 1'b0;
      lo_w_q   <= 1'b0;
    end else begin
      w_mode_q <= w_mode_d;
      if (rst_ws) begin
        full_n_q <= full_n_d;
        hf_n_q   <= hf_n_d;
        paf_n_q  <= paf_n_d;
        hi_w_q   <= hi_w_d;
        lo_w_q   <= lo_w_d;
      end
    end
  end

  // read domain
  logic empty_n_q, empty_n_d, pae_n_q, pae_n_d;
  logic r_async;
  assign r_async = (r_mode_q.timing == TM_ASYNC);

  always_comb begin
    empty_n_d = (rcnt != '0);
    pae_n_d   = !(rcnt <= r_pae_thr);
    lo_r_d    = lo_r_q;
    hi_r_d    = hi_r_q;
    if (r_async && (rcnt <= r_pae_thr) && (w_tog_rs[1] ^ lo_r_q)) lo_r_d = ~lo_r_q;
    if (r_async && (rcnt <  r_paf_thr) && (w_tog_rs[0] ^ hi_r_q)) hi_r_d = ~hi_r_q;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      r_mode_q  <= '{fwft: 1'b0, timing: TM_SYNC};
      empty_n_q <= 1'b0;
      pae_n_q   <= 1'b0;
      lo_r_q    <= 1'b0;
      hi_r_q    <= 1'b0;
    end else begin
      r_mode_q <= r_mode_d;
      if (rst_rs) begin
        empty_n_q <= empty_n_d;
        pae_n_q   <= pae_n_d;
        lo_r_q    <= lo_r_d;
        hi_r_q    <= hi_r_d;
      end
    end
  end

  // outputs
  assign empty_n_o        = empty_n_q;
  assign full_n_o         = full_n_q;
  assign half_full_n_o    = hf_n_q;
  assign almost_empty_n_o = r_async ? (hi_w_q ^ lo_r_q) : pae_n_q;
  assign almost_full_n_o  = w_async ? !(lo_w_q ^ hi_r_q) : paf_n_q;
endmodule

// File: rtl/ffg_checker.sv
module ffg_checker (
  input logic wclk,
  input logic rclk,
  input logic rst_n,
  input logic rst_ws,
  input logic rst_rs,
  input logic w_async,
  input logic r_async,
  input logic [1:0] w_mode,
  input logic [1:0] r_mode,
  input logic empty_n_o,
  input logic almost_empty_n_o,
  input logic half_full_n_o,
  input logic almost_full_n_o,
  input logic full_n_o
);
  AST_HELD_EMPTY: assert property (@(posedge rclk) disable iff (!rst_n)
    !rst_rs |-> !empty_n_o);  // R1

  AST_EMPTY_IN_PAE: assert property (@(posedge rclk) disable iff (!rst_n)
    (!r_async && !empty_n_o) |-> !almost_empty_n_o);  // R3

  AST_FULL_IN_PAF: assert property (@(posedge wclk) disable iff (!rst_n)
    (!w_async && !full_n_o) |-> !almost_full_n_o);  // R4

  AST_FULL_IN_HF: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n_o |-> !half_full_n_o);  // R5

  AST_WMODE_HELD: assert property (@(posedge wclk) disable iff (!rst_n)
    (rst_ws && $past(rst_ws)) |-> $stable(w_mode));  // R9

  AST_RMODE_HELD: assert property (@(posedge rclk) disable iff (!rst_n)
    (rst_rs && $past(rst_rs)) |-> $stable(r_mode));  // R9
endmodule

bind fifo_flag_gen ffg_checker chk_i (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rst_ws(rst_ws), .rst_rs(rst_rs),
  .w_async(w_async), .r_async(r_async), .w_mode(w_mode_q), .r_mode(r_mode_q),
  .empty_n_o(empty_n_o), .almost_empty_n_o(almost_empty_n_o),
  .half_full_n_o(half_full_n_o), .almost_full_n_o(almost_full_n_o),
  .full_n_o(full_n_o)
);

// File: tb/fifo_flag_gen_tb_top.sv
module fifo_flag_gen_tb_top;
  localparam int DEPTH = 64;
  localparam int OW = 6;
  localparam int PW = 8;
  localparam int NV = 24;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic cfg_fwft = 1'b0, cfg_async = 1'b0;
  logic [PW-1:0] wptr = '0, rptr = '0;
  logic [OW-1:0] n_off = 6'd5, m_off = 6'd7;
  logic e_n, pae_n, hf_n, paf_n, f_n;
  int total = 0, bad = 0;
  logic cur_fwft = 1'b0, cur_async = 1'b0;

  always #4 wclk = ~wclk;
  initial begin #3; forever #4 rclk = ~rclk; end

  fifo_flag_gen #(.DEPTH(DEPTH)) dut_i (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .cfg_fwft_i(cfg_fwft), .cfg_async_i(cfg_async),
    .wptr_i(wptr), .rptr_i(rptr), .empty_off_i(n_off), .full_off_i(m_off),
    .empty_n_o(e_n), .almost_empty_n_o(pae_n), .half_full_n_o(hf_n),
    .almost_full_n_o(paf_n), .full_n_o(f_n)
  );

  // row: {fwft, async, wptr[8], rptr[8], flags {e,pae,hf,paf,full}}
  localparam logic [22:0] VEC [NV] = '{
    {1'b0,1'b0,8'd10, 8'd10, 5'b00111},  // R2 R3 count 0
    {1'b0,1'b0,8'd15, 8'd10, 5'b10111},  // R3 count n
    {1'b0,1'b0,8'd16, 8'd10, 5'b11111},  // R3 count n+1
    {1'b0,1'b0,8'd42, 8'd10, 5'b11111},  // R5 count D/2
    {1'b0,1'b0,8'd43, 8'd10, 5'b11011},  // R5 count D/2+1
    {1'b0,1'b0,8'd66, 8'd10, 5'b11011},  // R4 count D-m-1
    {1'b0,1'b0,8'd67, 8'd10, 5'b11001},  // R4 count D-m
    {1'b0,1'b0,8'd73, 8'd10, 5'b11001},  // R4 count D-1
    {1'b0,1'b0,8'd74, 8'd10, 5'b11000},  // R4 count D
    {1'b0,1'b0,8'd27, 8'd250,5'b11011},  // R10 wrap count 33
    {1'b0,1'b0,8'd8,  8'd200,5'b11000},  // R10 wrap count 64
    {1'b1,1'b0,8'd10, 8'd10, 5'b00111},  // R6 count 0
    {1'b1,1'b0,8'd16, 8'd10, 5'b10111},  // R6 count n+1
    {1'b1,1'b0,8'd17, 8'd10, 5'b11111},  // R6 count n+2
    {1'b1,1'b0,8'd43, 8'd10, 5'b11111},  // R6 count D/2+1
    {1'b1,1'b0,8'd44, 8'd10, 5'b11011},  // R6 count D/2+2
    {1'b1,1'b0,8'd67, 8'd10, 5'b11011},  // R6 count D-m
    {1'b1,1'b0,8'd68, 8'd10, 5'b11001},  // R6 count D-m+1
    {1'b1,1'b0,8'd74, 8'd10, 5'b11001},  // R6 count D
    {1'b1,1'b0,8'd75, 8'd10, 5'b11000},  // R6 count D+1
    {1'b0,1'b1,8'd16, 8'd10, 5'b11111},  // R7 settled async
    {1'b0,1'b1,8'd67, 8'd10, 5'b11001},  // R7 settled async
    {1'b0,1'b1,8'd74, 8'd10, 5'b11000},  // R7 settled async
    {1'b0,1'b1,8'd15, 8'd10, 5'b10111}   // R7 settled async back to n
  };

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: flags got %b expected %b", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic fw, input logic as);
    rst_n = 1'b0;
    cfg_fwft = fw;
    cfg_async = as;
    wptr = '0;
    rptr = '0;
    #20;
    @(negedge wclk);
    rst_n = 1'b1;
    cur_fwft = fw;
    cur_async = as;
  endtask

  task automatic settle();
    repeat (12) @(posedge wclk);
    #2;
  endtask

  function automatic logic [4:0] flags();
    return {e_n, pae_n, hf_n, paf_n, f_n};
  endfunction

  initial begin
    // R1: flags during reset
    #10;
    check("R1", flags(), 5'b00111);
    do_reset(1'b0, 1'b0);
    settle();
    check("R1", flags(), 5'b00111);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][22] != cur_fwft || VEC[i][21] != cur_async) begin
        do_reset(VEC[i][22], VEC[i][21]);
        settle();
      end
      wptr = VEC[i][20:13];
      rptr = VEC[i][12:5];
      settle();
      check($sformatf("R2-table row %0d", i), flags(), VEC[i][4:0]);
    end

    // R7: async almost-empty rises on the write edge
    do_reset(1'b0, 1'b1);
    settle();
    wptr = 8'd15; rptr = 8'd10;
    settle();
    @(negedge wclk); wptr = 8'd16;
    @(posedge wclk); #1;
    check("R7 pae high on wclk", {4'b0, pae_n}, 5'd1);
    settle();
    // R7: async almost-empty falls on the read edge
    @(negedge rclk); rptr = 8'd11;
    @(posedge rclk); #1;
    check("R7 pae low on rclk", {4'b0, pae_n}, 5'd0);
    settle();
    // R7: async almost-full falls on the write edge
    wptr = 8'd66; rptr = 8'd10;
    settle();
    @(negedge wclk); wptr = 8'd67;
    @(posedge wclk); #1;
    check("R7 paf low on wclk", {4'b0, paf_n}, 5'd0);
    settle();

    // R8: synchronous almost-empty waits for the read domain
    do_reset(1'b0, 1'b0);
    settle();
    wptr = 8'd15; rptr = 8'd10;
    settle();
    @(negedge wclk); wptr = 8'd16;
    @(posedge wclk); #1;
    check("R8 pae still low", {4'b0, pae_n}, 5'd0);
    settle();
    check("R8 pae high later", {4'b0, pae_n}, 5'd1);

    // R9: option pins ignored after reset
    cfg_fwft = 1'b1;
    cfg_async = 1'b1;
    wptr = 8'd16; rptr = 8'd10;
    settle();
    check("R9 count 6 stays standard", flags(), 5'b11111);
    wptr = 8'd74;
    settle();
    check("R9 full at D", flags(), 5'b11000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule